// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Timer

This block gates the start of each outgoing frame on a shared medium. It measures the quiet interval that must separate frames and raises a permit to the transmitter once that interval has elapsed. All timing is counted in bit times through a single-cycle `bit_tick` enable, so the same logic serves any line rate from one system clock.

After reset, and after every frame or finished backoff (`tx_end`), the block defers. In half-duplex mode it waits until carrier sense is low, then counts a 96-bit gap. Carrier seen during the first 60 bit times abandons the gap, and the wait for a quiet line begins again. Carrier seen during the remaining 36 bit times is ignored, so the transmitter goes ahead and any overlap shows up as a collision. In full-duplex mode carrier is never consulted and only the 96-bit spacing is enforced.

Top module: `hdx_tx_defer`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `tx_permit` is low.
- R2: In half-duplex mode (`full_duplex` = 0), the gap does not start while `crs` is high after a frame ends, however many bit ticks pass.
- R3: `tx_permit` rises one clock after the 96th `bit_tick` counted since the gap began, and not before, provided `tx_pend` is high.
- R4: In half-duplex mode, `crs` high during the first 60 counted bit ticks of the gap abandons it. Once `crs` is low again, a full 96-tick gap is needed.
- R5: In half-duplex mode, `crs` rising after 60 or more bit ticks of the gap is ignored, and `tx_permit` rises at the normal time.
- R6: In full-duplex mode (`full_duplex` = 1), `crs` has no effect. The 96-tick gap starts right after `tx_end`.
- R7: Without `bit_tick` pulses the gap makes no progress, and `tx_permit` stays low.
- R8: Once raised, `tx_permit` stays high until `tx_start` is sampled high. It is low from the next clock on. A fresh gap is then required after `tx_end`.
- R9: `tx_start` while `tx_permit` is low, and `tx_end` outside a frame, are ignored. While a frame is in progress, `tx_permit` stays low until `tx_end` arrives.
- R10: `tx_permit` is high only while `tx_pend` is high. If the gap has completed but no frame is pending, `crs` high in half-duplex mode sends the block back to deferring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| full_duplex | input | 1 | 1 = full-duplex, carrier ignored |
| crs | input | 1 | Carrier sense, active high |
| tx_pend | input | 1 | A frame is waiting to be sent |
| tx_start | input | 1 | Transmitter takes the permit and starts the frame |
| tx_end | input | 1 | Frame finished or backoff finished |
| tx_permit | output | 1 | Frame may start now |

## Verification
The assertions assume that `bit_tick` is one clock cycle wide and synchronous to `clk`, and that `tx_end` arrives once for each frame taken. `full_duplex` may change at any cycle; the properties are stated so that they hold even then. The random stimulus drives `bit_tick` on about a third of the cycles and keeps carrier and pending levels in long runs, so that both sense windows are hit. It answers a permit with `tx_start` after a random delay and raises `tx_end` only while a frame is in progress. A small rate of stray `tx_start` and `tx_end` pulses is mixed in to exercise the ignored cases.

// File: rtl/defer_pkg.sv
package defer_pkg;

  typedef enum logic [1:0] {
    DF_WAIT  = 2'd0,
    DF_GAP   = 2'd1,
    DF_READY = 2'd2,
    DF_BUSY  = 2'd3
  } defer_state_e;

  // True while carrier sense may still abandon the gap.
  function automatic logic watch_open(input int unsigned elapsed,
                                      input int unsigned watch_len);
    return (elapsed < watch_len);
  endfunction

  // True once the full gap has been counted.
  function automatic logic gap_met(input int unsigned elapsed,
                                   input int unsigned gap_len);
    return (elapsed >= gap_len);
  endfunction

endpackage

// File: rtl/defer_gap_counter.sv
module defer_gap_counter
  import defer_pkg::*;
#(
  parameter int unsigned GAP_BITS = 96,
  parameter int unsigned CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             bit_tick,
  output logic [CNT_W-1:0] cnt,
  output logic             gap_done
);

  logic step;

  assign gap_done = gap_met(32'(cnt), GAP_BITS);
  assign step     = run && bit_tick && !gap_done;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + CNT_W'(1);
  end

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !bit_tick) |=> $stable(cnt));

  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= GAP_BITS);

endmodule

// File: rtl/defer_ctrl_fsm.sv
module defer_ctrl_fsm
  import defer_pkg::*;
#(
  parameter int unsigned WATCH_BITS = 60,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             crs,
  input  logic             tx_pend,
  input  logic             tx_start,
  input  logic             tx_end,
  input  logic [CNT_W-1:0] cnt,
  input  logic             gap_done,
  output logic             clear,
  output logic             run,
  output logic             tx_permit
);

  defer_state_e st, st_nx;

  // Named internal events
  logic in_watch;
  logic line_quiet;
  logic crs_restart;
  logic frame_taken;
  logic idle_sense;
  logic frame_over;

  assign in_watch    = watch_open(32'(cnt), WATCH_BITS);
  assign line_quiet  = full_duplex || !crs;
  assign crs_restart = (st == DF_GAP) && !full_duplex && crs && in_watch;
  assign frame_taken = (st == DF_READY) && tx_pend && tx_start;
  assign idle_sense  = (st == DF_READY) && !tx_pend && !full_duplex && crs;
  assign frame_over  = (st == DF_BUSY) && tx_end;

  always_comb begin
    st_nx = st;
    unique case (st)
      DF_WAIT:  if (line_quiet) st_nx = DF_GAP;
      DF_GAP: begin
        if (crs_restart)   st_nx = DF_WAIT;
        else if (gap_done) st_nx = DF_READY;
      end
      DF_READY: begin
        if (frame_taken)     st_nx = DF_BUSY;
        else if (idle_sense) st_nx = DF_WAIT;
      end
      DF_BUSY:  if (frame_over) st_nx = DF_WAIT;
      default:  st_nx = DF_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= DF_WAIT;
    else        st <= st_nx;
  end

  assign clear     = (st == DF_WAIT) || (st == DF_BUSY);
  assign run       = (st == DF_GAP);
  assign tx_permit = (st == DF_READY) && tx_pend;

  a_r2_no_count_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DF_WAIT) |=> (cnt == '0));

  a_r4_restart_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    crs_restart |=> ##1 (cnt == '0));

  a_r5_late_crs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == DF_GAP) && crs && !in_watch) |=> (st != DF_WAIT));

  a_r6_fd_never_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && (st == DF_GAP)) |=> (st != DF_WAIT));

  a_r8_permit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && tx_start) |=> !tx_permit);

  a_r9_busy_until_end: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == DF_BUSY) && !tx_end) |=> !tx_permit);

endmodule

// File: rtl/hdx_tx_defer.sv
module hdx_tx_defer
  import defer_pkg::*;
#(
  parameter int unsigned GAP_BITS   = 96,
  parameter int unsigned WATCH_BITS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic full_duplex,
  input  logic crs,
  input  logic tx_pend,
  input  logic tx_start,
  input  logic tx_end,
  output logic tx_permit
);

  localparam int unsigned CNT_W = $clog2(GAP_BITS + 1);

  logic [CNT_W-1:0] gap_cnt;
  logic             gap_done;
  logic             cnt_clear;
  logic             cnt_run;

  defer_gap_counter #(
    .GAP_BITS (GAP_BITS),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .run      (cnt_run),
    .bit_tick (bit_tick),
    .cnt      (gap_cnt),
    .gap_done (gap_done)
  );

  defer_ctrl_fsm #(
    .WATCH_BITS (WATCH_BITS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .crs         (crs),
    .tx_pend     (tx_pend),
    .tx_start    (tx_start),
    .tx_end      (tx_end),
    .cnt         (gap_cnt),
    .gap_done    (gap_done),
    .clear       (cnt_clear),
    .run         (cnt_run),
    .tx_permit   (tx_permit)
  );

  a_r3_permit_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> gap_done);

  a_r10_permit_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> tx_pend);

endmodule

// File: tb/sim_hdx_tx_defer.sv
module sim_hdx_tx_defer;

  localparam int GAP   = 96;
  localparam int WATCH = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic full_duplex = 1'b0;
  logic crs = 1'b0;
  logic tx_pend = 1'b0;
  logic tx_start = 1'b0;
  logic tx_end = 1'b0;
  logic tx_permit;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hdx_tx_defer u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_duplex(full_duplex),
    .crs(crs), .tx_pend(tx_pend), .tx_start(tx_start), .tx_end(tx_end),
    .tx_permit(tx_permit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tx_permit=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) tx_start = 1'b1;
    @(negedge clk) tx_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk) tx_end = 1'b1;
    @(negedge clk) tx_end = 1'b0;
  endtask

  // Reference: the rules of the gap, expressed as "bit ticks heard since quiet"
  int  m_phase;   // 0 defer, 1 counting, 2 gap done, 3 in frame
  int  m_heard;
  bit  m_on = 1'b0;

  function automatic bit may_abandon(int heard, bit fd, bit cs);
    return !fd && cs && (heard < WATCH);
  endfunction

  always @(posedge clk) begin
    if (m_on) begin
      if (!rst_n) begin
        m_phase = 0; m_heard = 0;
      end else begin
        case (m_phase)
          0: if (full_duplex || !crs) begin m_phase = 1; m_heard = 0; end
          1: if (may_abandon(m_heard, full_duplex, crs)) m_phase = 0;
             else if (m_heard == GAP) m_phase = 2;
             else if (bit_tick) m_heard = m_heard + 1;
          2: if (tx_pend && tx_start) m_phase = 3;
             else if (!tx_pend && !full_duplex && crs) m_phase = 0;
          default: if (tx_end) m_phase = 0;
        endcase
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tx_pend = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", tx_permit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", tx_permit, 1'b0);

    // R3 with stray events (R9)
    ticks(40);
    pulse_start();
    pulse_end();
    ticks(55);
    check("R3 before 96 ticks", tx_permit, 1'b0);
    ticks(1);
    @(negedge clk);
    check("R3 after 96 ticks", tx_permit, 1'b1);
    check("R9 stray start/end ignored", tx_permit, 1'b1);

    // R8 hold and release
    repeat (10) @(negedge clk);
    check("R8 held until start", tx_permit, 1'b1);
    pulse_start();
    check("R8 cleared by start", tx_permit, 1'b0);
    ticks(120);
    check("R9 in frame without end", tx_permit, 1'b0);

    // R2 and R4
    @(negedge clk) crs = 1'b1;
    pulse_end();
    ticks(100);
    check("R2 carrier holds gap", tx_permit, 1'b0);
    @(negedge clk) crs = 1'b0;
    ticks(30);
    @(negedge clk) crs = 1'b1;
    @(negedge clk) crs = 1'b0;
    ticks(95);
    check("R4 restart early", tx_permit, 1'b0);
    ticks(1);
    @(negedge clk);
    check("R4 full gap after restart", tx_permit, 1'b1);

    // R5
    pulse_start();
    pulse_end();
    ticks(70);
    @(negedge clk) crs = 1'b1;
    ticks(25);
    check("R5 before 96 ticks", tx_permit, 1'b0);
    ticks(1);
    @(negedge clk);
    check("R5 late carrier ignored", tx_permit, 1'b1);
    @(negedge clk) crs = 1'b0;

    // R10
    pulse_start();
    @(negedge clk) tx_pend = 1'b0;
    pulse_end();
    ticks(96);
    @(negedge clk);
    check("R10 no pending frame", tx_permit, 1'b0);
    @(negedge clk) tx_pend = 1'b1;
    #1 check("R10 permit follows pend", tx_permit, 1'b1);
    @(negedge clk) tx_pend = 1'b0;
    crs = 1'b1;
    @(negedge clk) tx_pend = 1'b1;
    #1 check("R10 carrier re-defers idle", tx_permit, 1'b0);
    @(negedge clk) crs = 1'b0;
    ticks(95);
    check("R10 gap again early", tx_permit, 1'b0);
    ticks(1);
    @(negedge clk);
    check("R10 gap again done", tx_permit, 1'b1);

    // R7
    pulse_start();
    pulse_end();
    repeat (300) @(negedge clk);
    check("R7 no ticks no progress", tx_permit, 1'b0);
    ticks(96);
    @(negedge clk);
    check("R7 ticks resume", tx_permit, 1'b1);

    // R6
    @(negedge clk) full_duplex = 1'b1;
    pulse_start();
    @(negedge clk) crs = 1'b1;
    pulse_end();
    ticks(95);
    check("R6 full duplex early", tx_permit, 1'b0);
    ticks(1);
    @(negedge clk);
    check("R6 carrier ignored", tx_permit, 1'b1);
    @(negedge clk) begin full_duplex = 1'b0; crs = 1'b0; end

    // Random phase against the reference
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    m_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 40000; cyc++) begin
      @(negedge clk);
      check("R3 R4 R5 R6 R8 random", tx_permit, (m_phase == 2) && tx_pend);
      bit_tick = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) crs = ~crs;
      if (($urandom % 120) == 0) tx_pend = ($urandom % 10) != 0;
      if (tx_permit && ($urandom % 4) == 0) tx_start = 1'b1;
      else tx_start = ($urandom % 200) == 0;
      if (m_phase == 3 && ($urandom % 30) == 0) tx_end = 1'b1;
      else tx_end = ($urandom % 300) == 0;
      if ((cyc % 5000) == 4999) full_duplex = ~full_duplex;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule